// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits between the host write path of a parallel NOR flash and its program/erase engine. Each host write arrives as a single-cycle strobe carrying an address and a data byte. The decoder recognises the two-write unlock prefix and the commands that follow it. It keeps track of the operating mode: array read, identifier read, query read, fast-program, program busy, chip-erase busy, block-erase busy and erase suspended. When a command completes, it fires a one-cycle request to the separate engine. The engine answers with a completion pulse, which returns the decoder from a busy mode.

Command matching looks only at the low twelve address lines and the data byte. In byte mode, the prefix keys are AAA and 555 and the query key is AA. In word mode, the keys are 555, 2AA and 55 on the low eleven lines. The program address and data, and the block address of a block-select request, appear on the target outputs in the same cycle as the request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (array read), suspended_o is 0 and every request output is low.
- R2: Each prefix write must hit its key. The first is data AA at the first key, the second is data 55 at the second key. A third write at the first key then selects the command: 90 enters identifier read (mode 1) and 20 enters fast-program (mode 3). In byte mode the keys are AAA and 555. In word mode they are 555 and 2AA, compared on bits 10:0. Address bits above these are ignored.
- R3: The prefix followed by A0 and then one more write pulses prog_start for one cycle, one cycle after that write. In that cycle tgt_addr and tgt_data carry that write's full address and data, and the mode becomes 4 (program busy).
- R4: A reset command is either a single write of F0 to any address or the prefix followed by F0 at any address. It pulses err_clear. It leaves identifier read for the base mode and leaves query read for the mode that preceded it.
- R5: A write that does not continue a started sequence discards the sequence and issues nothing. A later command write is then not taken as part of it.
- R6: In identifier read, only the reset command and the query command take effect. Any other command sequence leaves the mode unchanged and issues nothing.
- R7: Data 98 at the query key (AA in byte mode, 55 in word mode) enters query read (mode 2) from array read, from erase suspend or from identifier read.
- R8: In fast-program, A0 followed by one write starts a program. On completion the decoder returns to mode 3. The pair 90 then 00 leaves for the base mode. A single F0 pulses err_clear and stays in mode 3.
- R9: In modes 4 and 5, every write is ignored and op_done returns to the prior mode. The six-write sequence prefix, 80, prefix, 10 at the first key pulses chip_start and enters mode 5. At most one request output is high in any cycle.
- R10: The six-write sequence ending in 30 at a block address pulses blk_sel with tgt_addr set to that address and enters mode 6. In mode 6, each further write of 30 pulses blk_sel again, B0 pulses susp_req and enters mode 7 with suspended_o high, and op_done returns to mode 0.
- R11: In mode 7, a single 30 pulses resume_req and returns to mode 6 with suspended_o low. Erase set-up (80) is not accepted in mode 7. Identifier read, query read and fast-program may be entered from mode 7, and their exit or completion returns to mode 7. A program started in mode 7 returns to mode 7 when it finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1 selects the word-mode keys, 0 the byte-mode keys |
| wr_valid | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Engine finished the current operation |
| mode_o | output | 3 | Mode: 0 read, 1 ident, 2 query, 3 fast-program, 4 program busy, 5 chip busy, 6 block busy, 7 suspended |
| suspended_o | output | 1 | A block erase is suspended |
| prog_start | output | 1 | Start a program |
| chip_start | output | 1 | Start a chip erase |
| blk_sel | output | 1 | Add a block to the erase list |
| susp_req | output | 1 | Suspend the block erase |
| resume_req | output | 1 | Resume the block erase |
| err_clear | output | 1 | Clear the engine's error flag |
| tgt_addr | output | ADDR_W | Address for program or block select |
| tgt_data | output | 8 | Program data |

## Verification
The bench breaks the prefix with a near-miss address and then sends the command byte. A decoder that did not discard the partial sequence would enter identifier read there. It sends a full program sequence from identifier read, where a decoder that ignored the mode would start a program. It issues F0 in fast-program, which a wrong design would treat as an exit. It drives a full suspend round trip through identifier read and a nested program. There, an error in the return-mode bookkeeping would land in array read instead of the suspended state, and a resume honoured outside the suspended state would restart the erase too early. Word mode is run with byte-mode keys to catch a decoder that compares the wrong address lines.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_IDENT   = 3'd1,
    MD_QUERY   = 3'd2,
    MD_FASTPGM = 3'd3,
    MD_PGMBUSY = 3'd4,
    MD_CHIPBSY = 3'd5,
    MD_BLKBSY  = 3'd6,
    MD_SUSP    = 3'd7
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3, SQ_FPG, SQ_FEX
  } seq_e;

  localparam int KEY_W = 12;
  localparam logic [10:0] KEY_FIRST  = 11'h555;
  localparam logic [10:0] KEY_SECOND = 11'h2AA;
  localparam logic [10:0] KEY_QUERY  = 11'h055;

  localparam logic [7:0] CD_K1     = 8'hAA;
  localparam logic [7:0] CD_K2     = 8'h55;
  localparam logic [7:0] CD_IDENT  = 8'h90;
  localparam logic [7:0] CD_PGM    = 8'hA0;
  localparam logic [7:0] CD_FAST   = 8'h20;
  localparam logic [7:0] CD_ERASE  = 8'h80;
  localparam logic [7:0] CD_CHIP   = 8'h10;
  localparam logic [7:0] CD_BLOCK  = 8'h30;
  localparam logic [7:0] CD_SUSP   = 8'hB0;
  localparam logic [7:0] CD_QUERY  = 8'h98;
  localparam logic [7:0] CD_RESET  = 8'hF0;
  localparam logic [7:0] CD_FEXIT  = 8'h00;

  typedef struct packed {
    logic first_hit;
    logic second_hit;
    logic at_first;
    logic query_hit;
  } wr_class_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic blk;
    logic susp;
    logic res;
    logic clr;
  } req_t;

  // Byte-mode key is the word key shifted up, with the extra low line
  // equal to the inverse of the word key's bit 0.
  function automatic logic key_match(input logic [KEY_W-1:0] a,
                                     input logic word,
                                     input logic [10:0] wkey);
    logic [KEY_W-1:0] bkey;
    bkey = {wkey, ~wkey[0]};
    return word ? (a[10:0] == wkey) : (a == bkey);
  endfunction

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
(
  input  logic [KEY_W-1:0] addr,
  input  logic [7:0]       data,
  input  logic             word,
  output wr_class_t        cls
);

  logic hit_first_key, hit_second_key, hit_query_key;

  assign hit_first_key  = key_match(addr, word, KEY_FIRST);
  assign hit_second_key = key_match(addr, word, KEY_SECOND);
  assign hit_query_key  = key_match(addr, word, KEY_QUERY);

  assign cls.first_hit  = hit_first_key  && (data == CD_K1);
  assign cls.second_hit = hit_second_key && (data == CD_K2);
  assign cls.at_first   = hit_first_key;
  assign cls.query_hit  = hit_query_key  && (data == CD_QUERY);

endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] data,
  input  wr_class_t  cls,
  input  logic       op_done,
  output mode_e      mode_q,
  output logic       susp_q,
  output req_t       req
);

  seq_e  seq_q, seq_d;
  mode_e mode_d, ret_q, ret_d, base_mode, exit_mode;
  logic  susp_d, cmd_ok;

  assign base_mode = susp_q ? MD_SUSP : MD_READ;
  // Mode reached by an accepted reset command.
  assign exit_mode = (mode_q == MD_QUERY) ? ret_q :
                     (mode_q == MD_IDENT) ? base_mode : mode_q;
  assign cmd_ok    = (mode_q == MD_READ) || (mode_q == MD_SUSP);

  always_comb begin
    mode_d = mode_q;
    seq_d  = seq_q;
    ret_d  = ret_q;
    susp_d = susp_q;
    req    = '0;
    unique case (mode_q)
      MD_PGMBUSY, MD_CHIPBSY: begin
        if (op_done) begin
          mode_d = ret_q;
          seq_d  = SQ_IDLE;
        end
      end
      MD_BLKBSY: begin
        if (op_done) begin
          mode_d = MD_READ;
          seq_d  = SQ_IDLE;
        end else if (wr_valid) begin
          if (data == CD_SUSP) begin
            req.susp = 1'b1;
            mode_d   = MD_SUSP;
            susp_d   = 1'b1;
          end else if (data == CD_BLOCK) begin
            req.blk = 1'b1;
          end
        end
      end
      MD_FASTPGM: begin
        if (wr_valid) begin
          seq_d = SQ_IDLE;
          unique case (seq_q)
            SQ_FPG: begin
              req.prog = 1'b1;
              mode_d   = MD_PGMBUSY;
              ret_d    = MD_FASTPGM;
            end
            SQ_FEX: begin
              if (data == CD_FEXIT) mode_d = base_mode;
            end
            default: begin
              if (data == CD_PGM)        seq_d   = SQ_FPG;
              else if (data == CD_IDENT) seq_d   = SQ_FEX;
              else if (data == CD_RESET) req.clr = 1'b1;
            end
          endcase
        end
      end
      default: begin
        if (wr_valid) begin
          seq_d = SQ_IDLE;
          unique case (seq_q)
            SQ_IDLE: begin
              if (data == CD_RESET) begin
                req.clr = 1'b1;
                mode_d  = exit_mode;
              end else if (cls.first_hit) begin
                seq_d = SQ_K1;
              end else if (cls.query_hit && mode_q != MD_QUERY) begin
                ret_d  = mode_q;
                mode_d = MD_QUERY;
              end else if (data == CD_BLOCK && mode_q == MD_SUSP) begin
                req.res = 1'b1;
                mode_d  = MD_BLKBSY;
                susp_d  = 1'b0;
              end
            end
            SQ_K1: if (cls.second_hit) seq_d = SQ_K2;
            SQ_K2: begin
              if (data == CD_RESET) begin
                req.clr = 1'b1;
                mode_d  = exit_mode;
              end else if (cls.at_first && cmd_ok) begin
                if (data == CD_IDENT)      mode_d = MD_IDENT;
                else if (data == CD_PGM)   seq_d  = SQ_PGM;
                else if (data == CD_FAST)  mode_d = MD_FASTPGM;
                else if (data == CD_ERASE && mode_q == MD_READ) seq_d = SQ_E1;
              end
            end
            SQ_PGM: begin
              req.prog = 1'b1;
              mode_d   = MD_PGMBUSY;
              ret_d    = mode_q;
            end
            SQ_E1: if (cls.first_hit)  seq_d = SQ_E2;
            SQ_E2: if (cls.second_hit) seq_d = SQ_E3;
            SQ_E3: begin
              if (cls.at_first && data == CD_CHIP) begin
                req.chip = 1'b1;
                mode_d   = MD_CHIPBSY;
                ret_d    = MD_READ;
              end else if (data == CD_BLOCK) begin
                req.blk = 1'b1;
                mode_d  = MD_BLKBSY;
              end
            end
            default: seq_d = SQ_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      seq_q  <= SQ_IDLE;
      ret_q  <= MD_READ;
      susp_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      ret_q  <= ret_d;
      susp_q <= susp_d;
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_PGMBUSY || mode_q == MD_CHIPBSY) && !op_done) |=> (mode_q == $past(mode_q))); // R9
  AST_FAST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_FASTPGM && !wr_valid) |=> (mode_q == MD_FASTPGM)); // R8
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> ($past(mode_q) == MD_BLKBSY)); // R10

endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_t              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  mode_e             mode,
  output logic              prog_start,
  output logic              chip_start,
  output logic              blk_sel,
  output logic              susp_req,
  output logic              resume_req,
  output logic              err_clear,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data
);

  logic capture;
  assign capture = req.prog || req.blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start <= 1'b0;
      chip_start <= 1'b0;
      blk_sel    <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      err_clear  <= 1'b0;
      tgt_addr   <= '0;
      tgt_data   <= '0;
    end else begin
      prog_start <= req.prog;
      chip_start <= req.chip;
      blk_sel    <= req.blk;
      susp_req   <= req.susp;
      resume_req <= req.res;
      err_clear  <= req.clr;
      if (capture) begin
        tgt_addr <= addr;
        tgt_data <= data;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, chip_start, blk_sel, susp_req, resume_req})); // R9
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (mode == MD_PGMBUSY)); // R3
  AST_CHIP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |-> (mode == MD_CHIPBSY)); // R9
  AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(mode) == MD_SUSP)); // R11

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output logic [2:0]        mode_o,
  output logic              suspended_o,
  output logic              prog_start,
  output logic              chip_start,
  output logic              blk_sel,
  output logic              susp_req,
  output logic              resume_req,
  output logic              err_clear,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data
);

  wr_class_t cls;
  req_t      req;
  mode_e     mode_q;
  logic      susp_q;

  fcd_match u_match (
    .addr (wr_addr[KEY_W-1:0]),
    .data (wr_data),
    .word (word_mode),
    .cls  (cls)
  );

  fcd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .data     (wr_data),
    .cls      (cls),
    .op_done  (op_done),
    .mode_q   (mode_q),
    .susp_q   (susp_q),
    .req      (req)
  );

  fcd_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .addr       (wr_addr),
    .data       (wr_data),
    .mode       (mode_q),
    .prog_start (prog_start),
    .chip_start (chip_start),
    .blk_sel    (blk_sel),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .err_clear  (err_clear),
    .tgt_addr   (tgt_addr),
    .tgt_data   (tgt_data)
  );

  assign mode_o      = mode_q;
  assign suspended_o = susp_q;

  initial begin
    AST_ADDR_WIDE: assert (ADDR_W >= KEY_W); // R2
  end

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, word_mode = 1'b0, wr_valid = 1'b0, op_done = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  mode_o;
  logic suspended_o, prog_start, chip_start, blk_sel, susp_req, resume_req, err_clear;
  logic [19:0] tgt_addr;
  logic [7:0]  tgt_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done),
    .mode_o(mode_o), .suspended_o(suspended_o), .prog_start(prog_start),
    .chip_start(chip_start), .blk_sel(blk_sel), .susp_req(susp_req),
    .resume_req(resume_req), .err_clear(err_clear),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: history of data bytes in the pending sequence.
  int mm = 0, mret = 0;
  bit msus = 0;
  logic [7:0] hist[$];
  bit e_prog, e_chip, e_blk, e_sus, e_res, e_clr;
  logic [19:0] e_addr = '0;
  logic [7:0]  e_data = '0;

  function automatic bit at_key(input logic [19:0] a, input int which);
    logic [11:0] bk;
    logic [10:0] wk;
    case (which)
      1: begin wk = 11'h555; bk = 12'hAAA; end
      2: begin wk = 11'h2AA; bk = 12'h555; end
      default: begin wk = 11'h055; bk = 12'h0AA; end
    endcase
    return word_mode ? (a[10:0] == wk) : (a[11:0] == bk);
  endfunction

  task automatic leave();
    e_clr = 1;
    if (mm == 2) mm = mret;
    else if (mm == 1) mm = msus ? 7 : 0;
  endtask

  task automatic model_write(input logic [19:0] a, input logic [7:0] d);
    bit keep = 0;
    int n;
    if (mm == 4 || mm == 5) return;
    if (mm == 6) begin
      if (d == 8'hB0) begin e_sus = 1; mm = 7; msus = 1; end
      else if (d == 8'h30) begin e_blk = 1; e_addr = a; end
      return;
    end
    hist.push_back(d);
    n = hist.size();
    if (mm == 3) begin
      if (n == 1) begin
        if (d == 8'hA0 || d == 8'h90) keep = 1;
        else if (d == 8'hF0) e_clr = 1;
      end else if (hist[0] == 8'hA0) begin
        e_prog = 1; e_addr = a; e_data = d; mret = 3; mm = 4;
      end else if (d == 8'h00) mm = msus ? 7 : 0;
    end else begin
      case (n)
        1: if (d == 8'hF0) leave();
           else if (at_key(a, 1) && d == 8'hAA) keep = 1;
           else if (at_key(a, 3) && d == 8'h98 && mm != 2) begin mret = mm; mm = 2; end
           else if (d == 8'h30 && mm == 7) begin e_res = 1; mm = 6; msus = 0; end
        2: keep = at_key(a, 2) && d == 8'h55;
        3: if (d == 8'hF0) leave();
           else if (at_key(a, 1) && (mm == 0 || mm == 7)) begin
             if (d == 8'h90) mm = 1;
             else if (d == 8'hA0) keep = 1;
             else if (d == 8'h20) mm = 3;
             else if (d == 8'h80 && mm == 0) keep = 1;
           end
        4: if (hist[2] == 8'hA0) begin
             e_prog = 1; e_addr = a; e_data = d; mret = mm; mm = 4;
           end else keep = at_key(a, 1) && d == 8'hAA;
        5: keep = at_key(a, 2) && d == 8'h55;
        default: if (at_key(a, 1) && d == 8'h10) begin e_chip = 1; mm = 5; end
                 else if (d == 8'h30) begin e_blk = 1; e_addr = a; mm = 6; end
      endcase
    end
    if (!keep) hist.delete();
  endtask

  always @(posedge clk) begin
    {e_prog, e_chip, e_blk, e_sus, e_res, e_clr} = '0;
    if (!rst_n) begin
      mm = 0; mret = 0; msus = 0; hist.delete();
    end else if (op_done && mm >= 4 && mm <= 6) begin
      mm = (mm == 4) ? mret : 0;
      hist.delete();
    end else if (wr_valid) begin
      model_write(wr_addr, wr_data);
    end
  end

  // Cycle compare against the reference.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit bad;
      bad = (mode_o != mm[2:0]) || (suspended_o != msus) ||
            ({prog_start, chip_start, blk_sel, susp_req, resume_req, err_clear} !=
             {e_prog, e_chip, e_blk, e_sus, e_res, e_clr}) ||
            ((e_prog || e_blk) && tgt_addr != e_addr) ||
            (e_prog && tgt_data != e_data);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s cycle compare: mode=%0d susp=%0b strobes=%b addr=%h data=%h expected mode=%0d susp=%0b strobes=%b addr=%h data=%h",
          cur_req, mode_o, suspended_o,
          {prog_start, chip_start, blk_sel, susp_req, resume_req, err_clear},
          tgt_addr, tgt_data, mm, msus, {e_prog, e_chip, e_blk, e_sus, e_res, e_clr}, e_addr, e_data);
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s directed: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
  endtask

  function automatic logic [19:0] k1(); return word_mode ? 20'h555 : 20'hAAA; endfunction
  function automatic logic [19:0] k2(); return word_mode ? 20'h2AA : 20'h555; endfunction

  task automatic cmd(input logic [7:0] c);
    wr(k1(), 8'hAA); wr(k2(), 8'h55); wr(k1(), c);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", {mode_o, suspended_o, prog_start, chip_start, blk_sel, err_clear}, 0);

    cur_req = "R2"; cmd(8'h90); chk("R2", mode_o, 1);
    cur_req = "R6"; cmd(8'hA0); wr(20'h00100, 8'h11); chk("R6", mode_o, 1);
    cur_req = "R7"; wr(20'h000AA, 8'h98); chk("R7", mode_o, 2);
    cur_req = "R4"; wr(20'h3F000, 8'hF0); chk("R4", mode_o, 1);
    wr(20'h00000, 8'hF0); chk("R4", {mode_o, err_clear}, 4'b0001);

    cur_req = "R3"; cmd(8'hA0); wr(20'h12345, 8'h3C);
    chk("R3", {prog_start, mode_o}, 4'b1100);
    chk("R3", tgt_addr, 20'h12345); chk("R3", tgt_data, 8'h3C);
    cur_req = "R9"; wr(20'h00000, 8'hF0); cmd(8'h90); chk("R9", mode_o, 4);
    done_pulse(); chk("R9", mode_o, 0);

    cur_req = "R5"; wr(20'hAAA, 8'hAA); wr(20'h554, 8'h55); wr(20'hAAA, 8'h90);
    chk("R5", mode_o, 0);
    cur_req = "R2"; wr(20'hFFAAA, 8'hAA); wr(20'h7F555, 8'h55); wr(20'h80AAA, 8'h90);
    chk("R2", mode_o, 1);
    cur_req = "R4"; cmd(8'hF0); chk("R4", mode_o, 0);

    cur_req = "R8"; cmd(8'h20); chk("R8", mode_o, 3);
    wr(20'h00000, 8'hF0); chk("R8", {mode_o, err_clear}, 4'b0111);
    wr(20'h00000, 8'hA0); wr(20'h0ABCD, 8'h5A); chk("R8", prog_start, 1);
    done_pulse(); chk("R8", mode_o, 3);
    wr(20'h0, 8'h90); wr(20'h0, 8'h00); chk("R8", mode_o, 0);

    cur_req = "R9"; cmd(8'h80); cmd(8'h10); chk("R9", {chip_start, mode_o}, 4'b1101);
    wr(20'h0, 8'hB0); chk("R9", mode_o, 5);
    done_pulse(); chk("R9", mode_o, 0);

    cur_req = "R10"; cmd(8'h80); wr(k1(), 8'hAA); wr(k2(), 8'h55); wr(20'h30000, 8'h30);
    chk("R10", {blk_sel, mode_o}, 4'b1110); chk("R10", tgt_addr, 20'h30000);
    wr(20'h40000, 8'h30); chk("R10", tgt_addr, 20'h40000);
    wr(20'h0, 8'hB0); chk("R10", {susp_req, suspended_o, mode_o}, 5'b11111);

    cur_req = "R11"; cmd(8'h90); chk("R11", mode_o, 1);
    wr(20'h0, 8'h30); chk("R11", {resume_req, mode_o}, 4'b0001);
    wr(20'h0, 8'hF0); chk("R11", mode_o, 7);
    cmd(8'hA0); wr(20'h01000, 8'h00); chk("R11", mode_o, 4);
    done_pulse(); chk("R11", mode_o, 7);
    cmd(8'h80); chk("R11", mode_o, 7);
    wr(20'h0, 8'h30); chk("R11", {resume_req, suspended_o, mode_o}, 5'b10110);
    cur_req = "R10"; done_pulse(); chk("R10", mode_o, 0);

    cur_req = "R2"; word_mode = 1; @(negedge clk);
    cmd(8'h90); chk("R2", mode_o, 1); wr(20'h0, 8'hF0);
    wr(20'hAAA, 8'hAA); wr(20'h555, 8'h55); wr(20'hAAA, 8'h90); chk("R2", mode_o, 0);
    cur_req = "R7"; wr(20'h00055, 8'h98); chk("R7", mode_o, 2);
    wr(20'h0, 8'hF0); chk("R7", mode_o, 0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule